// File: doc/BRIEF.md
# Processor Supervisor with Watchdog

This block watches over a microprocessor and decides when it may run. It drives an active-low reset, a matching active-high reset, and an active-low watchdog alarm. Two things start a reset: a supply-good flag from an external comparator going false, or the manual reset request being pulled low. Every reset is stretched by a hold-off counter. The processor is released only after the hold-off period has passed with no cause present. Because that same stretch covers the manual reset request, it also debounces that input.

Once reset is released, a second counter measures the time since the last change on the watchdog strobe. A rising or falling change on the strobe clears the count. If the count reaches the watchdog period, the alarm output goes low. The alarm is also forced low whenever the supply flag is false, so with the watchdog disabled it acts as a plain low-supply indicator. Both periods are parameters given in clock cycles. The defaults are 200 ms and 1.6 s at 250 MHz.

Top module: `cpu_supervisor`

## Requirements
- R1: While `supply_ok` is sampled low at a clock edge, `rst_n_o` is low after that edge.
- R2: Suppose `supply_ok` is high, `mr_n` is inactive and `srst` is low. Then `rst_n_o` rises on the HOLD_CYCLES-th consecutive clock edge at which `supply_ok` is sampled high. Counting the first such edge as edge 0, that is edge HOLD_CYCLES-1.
- R3: `rst_o` is always the complement of `rst_n_o`.
- R4: `mr_n` passes through a two-flop synchronizer. A low `mr_n` sampled at edge k drives `rst_n_o` low after edge k+2. After `mr_n` returns high at edge m, release comes at edge m+1+HOLD_CYCLES. Any high pulse on `mr_n` shorter than the hold-off period produces no release pulse.
- R5: `wd_strobe` passes through a two-flop synchronizer. A change in either direction sampled at edge k clears the watchdog count at edge k+2.
- R6: Assume reset is released, `wd_en` is high and the strobe is quiet. Then `wd_n_o` goes low WD_CYCLES edges after the last count clear.
- R7: The watchdog count is held clear while `rst_n_o` is low, so its period begins only after release.
- R8: `wd_n_o` is low whenever `supply_ok` is low, whether or not the watchdog has expired.
- R9: While `wd_en` is low, `wd_n_o` equals `supply_ok`.
- R10: An expired watchdog returns `wd_n_o` high at the clear caused by the next strobe change or by reset going low.
- R11: A high `srst` drives `rst_n_o` low after the edge, clears the watchdog, and restarts the hold-off count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset of the block's own flops, active high |
| supply_ok | input | 1 | Registered supply-good flag from an external comparator |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| wd_strobe | input | 1 | Watchdog strobe from the processor, asynchronous |
| wd_en | input | 1 | Watchdog enable; when low the alarm tracks only the supply flag |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| wd_n_o | output | 1 | Watchdog alarm, active low |

## Verification
Each output is due at a different latency, and the bench samples at exactly that cycle:

| Stimulus | Output | Due after edge |
|---|---|---|
| Supply-good sampled low at edge k | Reset | k |
| Supply-good release, first high edge k | Reset | k+HOLD_CYCLES-1 |
| Manual request sampled low at edge k | Reset | k+2 (synchronizer) |
| Manual request back high at edge m | Reset release | m+1+HOLD_CYCLES |
| Strobe change sampled at edge k | Watchdog clear | k+2 |
| Reset goes low after edge k | Watchdog clear | k+1 |

Inputs are driven on the falling edge. Each check waits a counted number of rising edges and reads the outputs on the following falling edge. At every boundary the bench checks the cycle just before the change as well as the cycle of the change, so an off-by-one in any counter or synchronizer shows up as a failure.

// File: rtl/cpu_supervisor.sv
module cpu_supervisor #(
  parameter int unsigned HOLD_CYCLES = 50_000_000,
  parameter int unsigned WD_CYCLES   = 400_000_000
) (
  input  logic clk,
  input  logic srst,
  input  logic supply_ok,
  input  logic mr_n,
  input  logic wd_strobe,
  input  logic wd_en,
  output logic rst_n_o,
  output logic rst_o,
  output logic wd_n_o
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int WW = $clog2(WD_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);
  localparam logic [WW-1:0] WD_LAST   = WW'(WD_CYCLES - 1);

  logic mr_q1, mr_q2;
  logic stb_q1, stb_q2, stb_q3;
  logic [HW-1:0] hold_cnt;
  logic [WW-1:0] wd_cnt;
  logic rel_q, act_q, wd_exp;

  always_ff @(posedge clk) begin
    if (srst) begin
      mr_q1  <= 1'b1;
      mr_q2  <= 1'b1;
      stb_q1 <= 1'b0;
      stb_q2 <= 1'b0;
      stb_q3 <= 1'b0;
    end else begin
      mr_q1  <= mr_n;
      mr_q2  <= mr_q1;
      stb_q1 <= wd_strobe;
      stb_q2 <= stb_q1;
      stb_q3 <= stb_q2;
    end
  end

  wire cause  = !supply_ok || !mr_q2;
  wire stb_ev = stb_q2 ^ stb_q3;
  wire wd_clr = !rel_q || !wd_en || stb_ev;

  always_ff @(posedge clk) begin
    if (srst || cause) begin
      hold_cnt <= '0;
      rel_q    <= 1'b0;
      act_q    <= 1'b1;
    end else if (!rel_q) begin
      if (hold_cnt == HOLD_LAST) begin
        rel_q <= 1'b1;
        act_q <= 1'b0;
      end else begin
        hold_cnt <= hold_cnt + HW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (srst || wd_clr) begin
      wd_cnt <= '0;
      wd_exp <= 1'b0;
    end else if (!wd_exp) begin
      if (wd_cnt == WD_LAST) wd_exp <= 1'b1;
      else                   wd_cnt <= wd_cnt + WW'(1);
    end
  end

  assign rst_n_o = rel_q;
  assign rst_o   = act_q;
  assign wd_n_o  = supply_ok && !wd_exp;
endmodule

// File: rtl/cpu_supervisor_chk.sv
module cpu_supervisor_chk (
  input logic clk,
  input logic srst,
  input logic supply_ok,
  input logic mr_n,
  input logic wd_en,
  input logic rst_n_o,
  input logic rst_o,
  input logic wd_n_o
);
  AST_RST_COMPL: assert property (@(posedge clk) disable iff (srst) rst_o != rst_n_o); // R3
  AST_SUPPLY_RST: assert property (@(posedge clk) disable iff (srst) !supply_ok |=> !rst_n_o); // R1
  AST_RELEASE_SUPPLY: assert property (@(posedge clk) disable iff (srst) $rose(rst_n_o) |-> $past(supply_ok)); // R2
  AST_MR_RST: assert property (@(posedge clk) disable iff (srst) !$past(mr_n, 2) |=> !rst_n_o); // R4
  AST_WD_HELD: assert property (@(posedge clk) disable iff (srst) !rst_n_o |=> (wd_n_o == supply_ok)); // R7
  AST_WD_SUPPLY: assert property (@(posedge clk) disable iff (srst) !supply_ok |-> !wd_n_o); // R8
  AST_WD_OFF: assert property (@(posedge clk) disable iff (srst) !wd_en |=> (wd_n_o == supply_ok)); // R9
endmodule

bind cpu_supervisor cpu_supervisor_chk chk (
  .clk(clk), .srst(srst), .supply_ok(supply_ok), .mr_n(mr_n), .wd_en(wd_en),
  .rst_n_o(rst_n_o), .rst_o(rst_o), .wd_n_o(wd_n_o)
);

// File: tb/cpu_supervisor_test.sv
`timescale 1ns/1ps
module cpu_supervisor_test;
  localparam int HOLD = 8;
  localparam int WD   = 16;

  logic clk = 1'b0;
  logic srst, supply_ok, mr_n, wd_strobe, wd_en;
  logic rst_n_o, rst_o, wd_n_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cpu_supervisor #(.HOLD_CYCLES(HOLD), .WD_CYCLES(WD)) uut (
    .clk(clk), .srst(srst), .supply_ok(supply_ok), .mr_n(mr_n),
    .wd_strobe(wd_strobe), .wd_en(wd_en),
    .rst_n_o(rst_n_o), .rst_o(rst_o), .wd_n_o(wd_n_o)
  );

  // {supply_ok, mr_n, wd_en, wd_strobe, wait edges[7:0], exp rst_n, exp wd_n, req[3:0]}
  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {4'b0110, 8'd2,  2'b00, 4'd1},   // R1 supply low
    {4'b1110, 8'd7,  2'b01, 4'd2},   // R2 one edge before release
    {4'b1110, 8'd1,  2'b11, 4'd2},   // R2 release edge
    {4'b1110, 8'd15, 2'b11, 4'd6},   // R6 one edge before expiry
    {4'b1110, 8'd1,  2'b10, 4'd6},   // R6 expiry
    {4'b1111, 8'd2,  2'b10, 4'd5},   // R5 rise still in synchronizer
    {4'b1111, 8'd1,  2'b11, 4'd10},  // R10 rise clears alarm
    {4'b1111, 8'd10, 2'b11, 4'd5},   // R5 counting
    {4'b1110, 8'd17, 2'b11, 4'd5},   // R5 fall restarted the count
    {4'b1110, 8'd2,  2'b10, 4'd6},   // R6 expiry after the fall
    {4'b1100, 8'd1,  2'b11, 4'd9},   // R9 disable clears
    {4'b1100, 8'd40, 2'b11, 4'd9},   // R9 no expiry while disabled
    {4'b0100, 8'd1,  2'b00, 4'd8}    // R8 supply low forces alarm
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input int req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic chk_rst(input int req, input logic exp);
    check(req, rst_n_o, exp, "rst_n_o");
    check(3, rst_o, ~exp, "rst_o complement");  // R3
  endtask

  initial begin
    srst = 1'b1; supply_ok = 1'b0; mr_n = 1'b1; wd_strobe = 1'b0; wd_en = 1'b1;
    step(3);
    chk_rst(11, 1'b0);                      // R11 reset state
    check(8, wd_n_o, 1'b0, "wd_n_o in reset with bad supply");
    srst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {supply_ok, mr_n, wd_en, wd_strobe} = VEC[i][17:14];
      step(int'(VEC[i][13:6]));
      chk_rst(int'(VEC[i][3:0]), VEC[i][5]);
      check(int'(VEC[i][3:0]), wd_n_o, VEC[i][4], "wd_n_o");
    end

    // R4 manual reset, with bounce
    supply_ok = 1'b1; wd_en = 1'b1; wd_strobe = 1'b0; mr_n = 1'b1;
    step(20);
    chk_rst(2, 1'b1);
    mr_n = 1'b0;
    step(2);  chk_rst(4, 1'b1);
    step(1);  chk_rst(4, 1'b0);
    for (int b = 0; b < 5; b++) begin
      mr_n = (b < 3);
      step(1);
      chk_rst(4, 1'b0);
    end
    step(30); chk_rst(4, 1'b0);
    mr_n = 1'b1;
    step(9);  chk_rst(4, 1'b0);
    step(1);  chk_rst(4, 1'b1);

    // R7 count held during the long reset, starts at release
    step(15); check(7, wd_n_o, 1'b1, "wd_n_o before expiry after release");
    step(1);  check(6, wd_n_o, 1'b0, "wd_n_o expiry after release");

    // R10 reset assertion clears an expired alarm
    mr_n = 1'b0;
    step(3);  chk_rst(4, 1'b0);
    check(10, wd_n_o, 1'b0, "wd_n_o before clear by reset");
    step(1);  check(10, wd_n_o, 1'b1, "wd_n_o cleared by reset");
    mr_n = 1'b1;
    step(12); chk_rst(4, 1'b1);

    // R11 synchronous reset mid-run restarts hold-off
    srst = 1'b1;
    step(1);  chk_rst(11, 1'b0);
    check(11, wd_n_o, 1'b1, "wd_n_o after srst");
    srst = 1'b0;
    step(7);  chk_rst(11, 1'b0);
    step(1);  chk_rst(11, 1'b1);

    // R1 / R8 supply drop while running
    supply_ok = 1'b0;
    step(1);  chk_rst(1, 1'b0);
    check(8, wd_n_o, 1'b0, "wd_n_o on supply drop");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule